// File: doc/BRIEF.md
# Head Positioning Access Sequencer

This block is the clocked sequencer that steps a disk head positioner through its carriage access modes. After power-up it holds the carriage in a waiting condition. A start strobe then drives a return to cylinder zero. The carriage runs inward until it meets the inner guard band patterns, reverses, and runs outward back into the servo zone. It then settles on track. From the on-track condition a seek passes through accelerate, decelerate and a linear settle phase before it returns to on track.

A return to zero can also be requested at run time, either by the controller or by a manual switch. Each request has its own acceptance rule. The manual request holds the sequencer in the wait state for as long as the switch level stays high. The analog servo loops and the speed curves are outside the block. The block only decides the mode, the direction and the speed class, and emits the one-cycle start-rezero pulse that clears the address registers.

The state code and the five mode latches are views of one register. In that register, bit 7 is the rezero-mode latch, bit 3 the wait latch, bit 2 the control latch, bit 1 the linear latch and bit 0 the servo latch.

Top module: `hpa_seq`

## Requirements
- R1: While `por` is high at a clock edge, the state code becomes 0x08, the wait latch is set, the control, linear, servo and rezero latches are clear, and `seek_err` and `strz` are low.
- R2: In the wait state with no rezero pending, `start_strb` moves to start (0x00) at the next edge. Start always moves to move-in (0x80) at the next edge, and `strz` is high for exactly that first move-in cycle.
- R3: In move-in, `spd_hi` is high only until `gb1` has been seen. It is low in the same cycle `gb1` is high, including the first move-in cycle, and it stays low for the rest of move-in.
- R4: `gb2` in move-in leads to turn-around (0x84), which has the control latch set, `mv_out` high and `spd_hi` high. Turn-around persists until `gb1` is high.
- R5: `gb1` in turn-around leads to move-out (0x86), which has `mv_out` high and `spd_hi` low. Move-out leads to rezero linear (0x06) once both guard bands are low, and rezero linear leads to on track (0x07) only when `settle_done` and `on_trk` are both high.
- R6: In on track, `seek_req` starts a seek at accelerate (0x05) and latches `seek_dir` onto `mv_out` for the seek states. `end_acc` then moves to decelerate (0x01), `end_dec` to seek linear (0x03), and `settle_done` with `on_trk` back to on track. `seek_req` in any other state is ignored.
- R7: A controller rezero is accepted when `sel` is high and the state is on track, or whenever a seek error is latched. Otherwise it is ignored. Once it is accepted, the next state is wait (0x08) with `seek_err` cleared, and the state after that is start (0x00).
- R8: A manual rezero is accepted only in on track with `offs_act` and `rw_act` both low. Once accepted, the sequencer enters wait, stays there while `sw_lvl` is high, and moves to start at the edge after `sw_lvl` is seen low.
- R9: `seek_err_in` sets `seek_err` only in the seek states 0x05, 0x01 and 0x03. Once set, `seek_err` holds until a rezero is accepted.
- R10: The latch outputs equal bits of the state code: `rz_l` is bit 7, `wait_l` bit 3, `ctl_l` bit 2, `lin_l` bit 1 and `srv_l` bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| start_strb | input | 1 | Start-sequence strobe |
| sel | input | 1 | Drive selected |
| sys_rz_req | input | 1 | Controller rezero request |
| man_rz_req | input | 1 | Manual rezero request |
| sw_lvl | input | 1 | Manual switch level |
| offs_act | input | 1 | Offset operation active |
| rw_act | input | 1 | Read or write active |
| seek_req | input | 1 | Seek start |
| seek_dir | input | 1 | Seek direction, 1 = outward |
| gb1 | input | 1 | Guard band pattern 1 detected |
| gb2 | input | 1 | Guard band pattern 2 detected |
| end_acc | input | 1 | Servo end-accelerate event |
| end_dec | input | 1 | Servo end-decelerate event |
| on_trk | input | 1 | Head on track |
| settle_done | input | 1 | Linear settle timer expired |
| seek_err_in | input | 1 | Seek error detected |
| wait_l | output | 1 | Wait latch |
| ctl_l | output | 1 | Control latch |
| lin_l | output | 1 | Linear mode latch |
| srv_l | output | 1 | Servo latch |
| rz_l | output | 1 | Rezero mode latch |
| state_code | output | 8 | Current state code |
| mv_out | output | 1 | Move-out gate |
| strz | output | 1 | Start-rezero pulse |
| spd_hi | output | 1 | High speed select |
| seek_err | output | 1 | Latched seek error |

## Verification
The properties take for granted that the guard band inputs follow the physical order of a real inward sweep. In that order `gb2` never appears in move-in before the head has passed `gb1`, and `gb1` is low while `gb2` is high. Servo events are also assumed to arrive only in the state that expects them. The stimulus respects this by raising each servo or guard band input only in the cycle that models its event, and by lowering it before the next. A rezero request is held for a single cycle, except where the acceptance window or the switch hold is the thing under test.

// File: rtl/hpa_pkg.sv
package hpa_pkg;
  localparam int CODE_W = 8;
  localparam int B_RZ   = 7;
  localparam int B_WAIT = 3;
  localparam int B_CTL  = 2;
  localparam int B_LIN  = 1;
  localparam int B_SRV  = 0;

  // The state code doubles as the latch vector.
  typedef enum logic [CODE_W-1:0] {
    ST_WAIT  = 8'h08,
    ST_START = 8'h00,
    ST_MVIN  = 8'h80,
    ST_TURN  = 8'h84,
    ST_MVOUT = 8'h86,
    ST_RZLIN = 8'h06,
    ST_ONTRK = 8'h07,
    ST_ACCEL = 8'h05,
    ST_DECEL = 8'h01,
    ST_SKLIN = 8'h03
  } hpa_state_e;

  function automatic logic is_seek(input hpa_state_e s);
    return (s == ST_ACCEL) || (s == ST_DECEL) || (s == ST_SKLIN);
  endfunction

  function automatic logic is_rz_out(input hpa_state_e s);
    return (s == ST_TURN) || (s == ST_MVOUT);
  endfunction
endpackage

// File: rtl/hpa_req_qual.sv
module hpa_req_qual
  import hpa_pkg::*;
(
  input  hpa_state_e st,
  input  logic       err_q,
  input  logic       sel,
  input  logic       sys_rz_req,
  input  logic       man_rz_req,
  input  logic       offs_act,
  input  logic       rw_act,
  output logic       take_sys,
  output logic       take_man
);
  logic idle_on;
  assign idle_on  = (st == ST_ONTRK);
  assign take_sys = sys_rz_req & ((sel & idle_on) | err_q);
  assign take_man = man_rz_req & idle_on & ~offs_act & ~rw_act & ~take_sys;
endmodule

// File: rtl/hpa_fsm.sv
module hpa_fsm
  import hpa_pkg::*;
(
  input  logic       clk,
  input  logic       por,
  input  logic       start_strb,
  input  logic       sw_lvl,
  input  logic       seek_req,
  input  logic       seek_dir,
  input  logic       gb1,
  input  logic       gb2,
  input  logic       end_acc,
  input  logic       end_dec,
  input  logic       on_trk,
  input  logic       settle_done,
  input  logic       seek_err_in,
  input  logic       take_sys,
  input  logic       take_man,
  output hpa_state_e st,
  output logic       err_q,
  output logic       strz,
  output logic       dir_q,
  output logic       man_hold
);
  hpa_state_e nx;
  logic pend_q, man_q;
  logic pend_d, man_d, err_d, strz_d, dir_d;

  assign man_hold = (st == ST_WAIT) & pend_q & man_q & sw_lvl;

  always_comb begin
    nx     = st;
    pend_d = pend_q;
    man_d  = man_q;
    strz_d = 1'b0;
    dir_d  = dir_q;
    err_d  = err_q | (seek_err_in & is_seek(st));
    if (take_sys | take_man) begin
      nx     = ST_WAIT;
      pend_d = 1'b1;
      man_d  = take_man;
      err_d  = 1'b0;
    end else begin
      case (st)
        ST_WAIT: begin
          if (pend_q) begin
            if (!(man_q && sw_lvl)) begin
              nx     = ST_START;
              pend_d = 1'b0;
            end
          end else if (start_strb) begin
            nx = ST_START;
          end
        end
        ST_START: begin
          nx     = ST_MVIN;
          strz_d = 1'b1;
        end
        ST_MVIN:  if (gb2) nx = ST_TURN;
        ST_TURN:  if (gb1) nx = ST_MVOUT;
        ST_MVOUT: if (!gb1 && !gb2) nx = ST_RZLIN;
        ST_RZLIN: if (settle_done && on_trk) nx = ST_ONTRK;
        ST_SKLIN: if (settle_done && on_trk) nx = ST_ONTRK;
        ST_ONTRK: begin
          if (seek_req) begin
            nx    = ST_ACCEL;
            dir_d = seek_dir;
          end
        end
        ST_ACCEL: if (end_acc) nx = ST_DECEL;
        ST_DECEL: if (end_dec) nx = ST_SKLIN;
        default:  nx = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      st     <= ST_WAIT;
      pend_q <= 1'b0;
      man_q  <= 1'b0;
      err_q  <= 1'b0;
      strz   <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      st     <= nx;
      pend_q <= pend_d;
      man_q  <= man_d;
      err_q  <= err_d;
      strz   <= strz_d;
      dir_q  <= dir_d;
    end
  end
endmodule

// File: rtl/hpa_drive.sv
module hpa_drive
  import hpa_pkg::*;
(
  input  logic       clk,
  input  logic       por,
  input  hpa_state_e st,
  input  logic       gb1,
  input  logic       dir_q,
  output logic       mv_out,
  output logic       spd_hi
);
  logic gbl1_q;

  always_ff @(posedge clk) begin
    if (por) gbl1_q <= 1'b0;
    else if (st != ST_MVIN) gbl1_q <= 1'b0;
    else if (gb1) gbl1_q <= 1'b1;
  end

  assign mv_out = is_rz_out(st) | (is_seek(st) & dir_q);
  assign spd_hi = ((st == ST_MVIN) & ~gbl1_q & ~gb1) | (st == ST_TURN);
endmodule

// File: rtl/hpa_seq.sv
module hpa_seq
  import hpa_pkg::*;
(
  input  logic              clk,
  input  logic              por,
  input  logic              start_strb,
  input  logic              sel,
  input  logic              sys_rz_req,
  input  logic              man_rz_req,
  input  logic              sw_lvl,
  input  logic              offs_act,
  input  logic              rw_act,
  input  logic              seek_req,
  input  logic              seek_dir,
  input  logic              gb1,
  input  logic              gb2,
  input  logic              end_acc,
  input  logic              end_dec,
  input  logic              on_trk,
  input  logic              settle_done,
  input  logic              seek_err_in,
  output logic              wait_l,
  output logic              ctl_l,
  output logic              lin_l,
  output logic              srv_l,
  output logic              rz_l,
  output logic [CODE_W-1:0] state_code,
  output logic              mv_out,
  output logic              strz,
  output logic              spd_hi,
  output logic              seek_err
);
  hpa_state_e st;
  logic err_q, dir_q, take_sys, take_man, take_any, man_hold;

  hpa_req_qual u_qual (
    .st(st), .err_q(err_q), .sel(sel), .sys_rz_req(sys_rz_req),
    .man_rz_req(man_rz_req), .offs_act(offs_act), .rw_act(rw_act),
    .take_sys(take_sys), .take_man(take_man)
  );

  hpa_fsm u_fsm (
    .clk(clk), .por(por), .start_strb(start_strb), .sw_lvl(sw_lvl),
    .seek_req(seek_req), .seek_dir(seek_dir), .gb1(gb1), .gb2(gb2),
    .end_acc(end_acc), .end_dec(end_dec), .on_trk(on_trk),
    .settle_done(settle_done), .seek_err_in(seek_err_in),
    .take_sys(take_sys), .take_man(take_man), .st(st), .err_q(err_q),
    .strz(strz), .dir_q(dir_q), .man_hold(man_hold)
  );

  hpa_drive u_drive (
    .clk(clk), .por(por), .st(st), .gb1(gb1), .dir_q(dir_q),
    .mv_out(mv_out), .spd_hi(spd_hi)
  );

  assign take_any   = take_sys | take_man;
  assign state_code = st;
  assign rz_l       = st[B_RZ];
  assign wait_l     = st[B_WAIT];
  assign ctl_l      = st[B_CTL];
  assign lin_l      = st[B_LIN];
  assign srv_l      = st[B_SRV];
  assign seek_err   = err_q;
endmodule

// File: rtl/hpa_seq_chk.sv
module hpa_seq_chk (
  input logic       clk,
  input logic       por,
  input logic       gb2,
  input logic       end_acc,
  input logic       take_any,
  input logic       man_hold,
  input logic [7:0] state_code,
  input logic       wait_l,
  input logic       ctl_l,
  input logic       mv_out,
  input logic       strz,
  input logic       seek_err
);
  p_strz_single_r2: assert property (@(posedge clk) disable iff (por)
    strz |=> !strz);
  p_strz_in_mvin_r2: assert property (@(posedge clk) disable iff (por)
    strz |-> state_code == 8'h80);
  p_turn_r4: assert property (@(posedge clk) disable iff (por)
    (state_code == 8'h80 && gb2 && !take_any) |=>
      (state_code == 8'h84 && mv_out && ctl_l));
  p_decel_r6: assert property (@(posedge clk) disable iff (por)
    (state_code == 8'h05 && end_acc && !take_any) |=>
      (state_code == 8'h01 && !ctl_l));
  p_take_wait_r7: assert property (@(posedge clk) disable iff (por)
    take_any |=> (state_code == 8'h08 && wait_l && !seek_err));
  p_switch_hold_r8: assert property (@(posedge clk) disable iff (por)
    (man_hold && !take_any) |=> state_code == 8'h08);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (por)
    (seek_err && !take_any) |=> seek_err);
endmodule

bind hpa_seq hpa_seq_chk u_chk (
  .clk(clk), .por(por), .gb2(gb2), .end_acc(end_acc),
  .take_any(take_any), .man_hold(man_hold), .state_code(state_code),
  .wait_l(wait_l), .ctl_l(ctl_l), .mv_out(mv_out), .strz(strz),
  .seek_err(seek_err)
);

// File: tb/sim_hpa_seq.sv
module sim_hpa_seq;
  logic clk = 1'b0;
  logic por = 1'b1;
  logic start_strb = 0, sel = 1, sys_rz_req = 0, man_rz_req = 0, sw_lvl = 0;
  logic offs_act = 0, rw_act = 0, seek_req = 0, seek_dir = 0;
  logic gb1 = 0, gb2 = 0, end_acc = 0, end_dec = 0, on_trk = 0;
  logic settle_done = 0, seek_err_in = 0;
  logic wait_l, ctl_l, lin_l, srv_l, rz_l, mv_out, strz, spd_hi, seek_err;
  logic [7:0] state_code;

  typedef struct packed {
    logic [7:0] code;
    logic mv, sz, spd, err;
  } exp_t;

  exp_t  qe[$];
  string qt[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hpa_seq u0 (.*);

  task automatic cyc(input logic [7:0] c, input logic m, input logic z,
                     input logic s, input logic e, input string tag);
    exp_t x;
    x = '{code: c, mv: m, sz: z, spd: s, err: e};
    qe.push_back(x);
    qt.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor: pops one expected item per edge once the outputs settle.
  always @(posedge clk) begin
    #1;
    if (qe.size() > 0) begin
      exp_t e;
      string t;
      logic [4:0] lat_exp, lat_act;
      e = qe.pop_front();
      t = qt.pop_front();
      lat_exp = {e.code[7], e.code[3], e.code[2], e.code[1], e.code[0]};
      lat_act = {rz_l, wait_l, ctl_l, lin_l, srv_l};
      n_cmp++;
      if (state_code !== e.code || mv_out !== e.mv || strz !== e.sz ||
          spd_hi !== e.spd || seek_err !== e.err || lat_act !== lat_exp) begin
        n_bad++;
        $display("FAIL %s (latches R10): act code=%h mv=%b strz=%b spd=%b err=%b lat=%b exp code=%h mv=%b strz=%b spd=%b err=%b lat=%b",
                 t, state_code, mv_out, strz, spd_hi, seek_err, lat_act,
                 e.code, e.mv, e.sz, e.spd, e.err, lat_exp);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all R) act=hung exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset
    cyc(8'h08, 0, 0, 0, 0, "R1 reset");
    cyc(8'h08, 0, 0, 0, 0, "R1 reset held");
    por = 0;
    cyc(8'h08, 0, 0, 0, 0, "R1 idle wait");
    // R2 power-up rezero
    start_strb = 1; cyc(8'h00, 0, 0, 0, 0, "R2 start");
    start_strb = 0; cyc(8'h80, 0, 1, 1, 0, "R2 move in with strz");
    cyc(8'h80, 0, 0, 1, 0, "R2 strz single");
    // R3 speed
    gb1 = 1; cyc(8'h80, 0, 0, 0, 0, "R3 gb1 slows");
    gb1 = 0; cyc(8'h80, 0, 0, 0, 0, "R3 low speed kept");
    // R4/R5 turn and out
    gb2 = 1; cyc(8'h84, 1, 0, 1, 0, "R4 turn around");
    cyc(8'h84, 1, 0, 1, 0, "R4 turn held");
    gb2 = 0; gb1 = 1; cyc(8'h86, 1, 0, 0, 0, "R5 move out");
    gb1 = 0; cyc(8'h06, 0, 0, 0, 0, "R5 rezero linear");
    settle_done = 1; cyc(8'h06, 0, 0, 0, 0, "R5 needs on track");
    on_trk = 1; cyc(8'h07, 0, 0, 0, 0, "R5 on track");
    settle_done = 0; on_trk = 0;
    // R7 unselected, R9 no error outside seek
    sel = 0; sys_rz_req = 1; cyc(8'h07, 0, 0, 0, 0, "R7 unselected ignored");
    sel = 1; sys_rz_req = 0;
    seek_err_in = 1; cyc(8'h07, 0, 0, 0, 0, "R9 no error outside seek");
    seek_err_in = 0;
    // R6 outward seek
    seek_req = 1; seek_dir = 1; cyc(8'h05, 1, 0, 0, 0, "R6 accelerate");
    seek_req = 0; cyc(8'h05, 1, 0, 0, 0, "R6 accelerate held");
    end_acc = 1; cyc(8'h01, 1, 0, 0, 0, "R6 decelerate");
    end_acc = 0; end_dec = 1; cyc(8'h03, 1, 0, 0, 0, "R6 seek linear");
    end_dec = 0; seek_err_in = 1; cyc(8'h03, 1, 0, 0, 1, "R9 error latched");
    seek_err_in = 0; settle_done = 1; on_trk = 1;
    cyc(8'h07, 0, 0, 0, 1, "R9 error held");
    settle_done = 0; on_trk = 0;
    // R7 accepted through error
    sel = 0; sys_rz_req = 1; cyc(8'h08, 0, 0, 0, 0, "R7 taken after error");
    sel = 1; sys_rz_req = 0; gb1 = 1; cyc(8'h00, 0, 0, 0, 0, "R7 released");
    cyc(8'h80, 0, 1, 0, 0, "R3 gb1 on entry");
    gb1 = 0; gb2 = 1; cyc(8'h84, 1, 0, 1, 0, "R4 turn again");
    gb2 = 0; gb1 = 1; cyc(8'h86, 1, 0, 0, 0, "R5 move out again");
    gb1 = 0; cyc(8'h06, 0, 0, 0, 0, "R5 linear again");
    settle_done = 1; on_trk = 1; cyc(8'h07, 0, 0, 0, 0, "R5 on track again");
    settle_done = 0; on_trk = 0;
    // R6 inward seek with busy rezero ignored
    seek_req = 1; seek_dir = 0; cyc(8'h05, 0, 0, 0, 0, "R6 inward seek");
    seek_req = 0; end_acc = 1; sys_rz_req = 1;
    cyc(8'h01, 0, 0, 0, 0, "R7 busy ignored");
    end_acc = 0; sys_rz_req = 0; end_dec = 1; cyc(8'h03, 0, 0, 0, 0, "R6 inward linear");
    end_dec = 0; settle_done = 1; on_trk = 1; cyc(8'h07, 0, 0, 0, 0, "R6 seek done");
    settle_done = 0; on_trk = 0;
    // R8 manual
    rw_act = 1; man_rz_req = 1; cyc(8'h07, 0, 0, 0, 0, "R8 blocked by rw");
    rw_act = 0; offs_act = 1; cyc(8'h07, 0, 0, 0, 0, "R8 blocked by offset");
    offs_act = 0; sw_lvl = 1; cyc(8'h08, 0, 0, 0, 0, "R8 taken");
    man_rz_req = 0; cyc(8'h08, 0, 0, 0, 0, "R8 held by switch");
    cyc(8'h08, 0, 0, 0, 0, "R8 still held");
    sw_lvl = 0; cyc(8'h00, 0, 0, 0, 0, "R8 released");
    seek_req = 1; cyc(8'h80, 0, 1, 1, 0, "R6 seek ignored at start");
    cyc(8'h80, 0, 0, 1, 0, "R6 seek ignored in move in");
    seek_req = 0;
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule